// File: doc/BRIEF.md
# Symmetric PWM Time-Base Counter

This block is the time base of one pulse-width-modulation channel. In its running mode a counter rises by one per clock from zero to a programmable period. It then falls by one per clock back to zero and repeats, so one full cycle lasts twice the period. The block gives single-cycle pulses when the counter matches zero, the period and an active compare value. It also drives a PWM output that is cleared by the zero match and set by the period match.

Software reaches the block through a small register port. Writes are synchronous and reads are combinational. Through this port software can program the period, with either an immediate load or a load deferred to the next zero match. It can also program a double-buffered compare value, select the run mode, and read a status word. The status word holds the count direction and a sticky flag that records when the counter reached its all-ones value.

Software may overwrite the counter at any time. Such a write keeps the current direction and suppresses every match on the value just written. If software writes zero while the counter is falling, the counter underflows to all-ones and stays above the period until it counts down through zero by itself. If software writes the period value while the counter is rising, the period match is skipped and the counter keeps rising.

Top module: `pwm_updown_timebase`

## Requirements
- R1: After reset the counter is 0, the status direction bit (status bit 0) is 1 (up), the max flag (status bit 1) is 0, the PWM output is 0 and the mode is stopped.
- R2: Register addresses are 0 control, 1 period, 2 counter, 3 compare and 4 status. In the control register, bits [1:0] = 01 selects up-down running. While running, the counter rises by one per clock until it equals the period, then falls by one per clock until it equals 0. The direction bit reads 1 while rising and 0 while falling, and flips on the clock after the counter holds the period or 0.
- R3: While running, the zero event, the period event and the compare event are one-clock pulses. Each is high in the cycle the counter equals 0, the active period or the active compare value, respectively.
- R4: The PWM output goes to 0 on the clock after a zero event and to 1 on the clock after a period event, and holds otherwise.
- R5: Any control mode other than 01 (00, 10, 11) stops the block: the counter and direction hold and no events occur.
- R6: Control bit 2 selects the period load. When it is 1, a period write is active on the next clock. When it is 0, the write goes to a buffer that becomes active on the clock after a zero event. Reading address 1 returns the active period.
- R7: A compare write goes to a buffer that becomes active on the clock after a zero event. Reading address 3 returns the active compare value.
- R8: The max flag is set on the clock after the counter holds all-ones while running, and stays set. Writing status with bit 1 = 1 clears it. Writing status with bit 1 = 0 has no effect on it.
- R9: A write to the counter loads the value on the next clock, leaves the direction unchanged, and suppresses all events for the cycle in which the written value is present.
- R10: A counter write of 0 while falling leads to an underflow to all-ones on the next clock. The counter then keeps falling above the period and reverses only on a zero reached by counting.
- R11: A counter write of the period value while rising gives no period event and no reversal, and the counter continues to rise past the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| ctr_o | output | 16 | Current counter value |
| zero_evt | output | 1 | Counter-equals-zero pulse |
| prd_evt | output | 1 | Counter-equals-period pulse |
| cmp_evt | output | 1 | Counter-equals-compare pulse |
| pwm_o | output | 1 | Action-qualified PWM output |

## Verification
The embedded properties check, on every cycle, the one-step counting between matches, reversal after each match, and freezing when stopped. They also check that events are suppressed after a counter write, that the compare buffer and the buffered period hold between zero events, that the max flag stays latched, and how the output responds to each event.

Other behaviour can only be shown by the bench scenarios. One is the exact order and counter values of the events over whole cycles. Others are the underflow to all-ones after writing zero while falling, and the skipped period match after writing the period while rising. The last is the visible difference between immediate and buffered period loading as read back through the register port.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
   typedef enum logic [1:0] {
      MODE_STOP = 2'b00,
      MODE_UPDN = 2'b01,
      MODE_RSV2 = 2'b10,
      MODE_RSV3 = 2'b11
   } tb_mode_e;

   localparam int unsigned A_CTRL = 0;
   localparam int unsigned A_PRD  = 1;
   localparam int unsigned A_CNT  = 2;
   localparam int unsigned A_CMP  = 3;
   localparam int unsigned A_STAT = 4;
endpackage

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter #(
   parameter int unsigned CTR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CTR_W-1:0] prd_act,
   input  logic [CTR_W-1:0] cmp_act,
   input  logic             ld_en,
   input  logic [CTR_W-1:0] ld_val,
   output logic [CTR_W-1:0] ctr,
   output logic             dir_up,
   output logic             zero_evt,
   output logic             prd_evt,
   output logic             cmp_evt
);
   logic blk_q;

   assign zero_evt = run && !blk_q && (ctr == '0);
   assign prd_evt  = run && !blk_q && (ctr == prd_act);
   assign cmp_evt  = run && !blk_q && (ctr == cmp_act);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctr    <= '0;
         dir_up <= 1'b1;
         blk_q  <= 1'b0;
      end else begin
         blk_q <= ld_en;
         if (zero_evt)     dir_up <= 1'b1;
         else if (prd_evt) dir_up <= 1'b0;
         if (ld_en) begin
            ctr <= ld_val;
         end else if (run) begin
            if (zero_evt)     ctr <= ctr + 1'b1;
            else if (prd_evt) ctr <= ctr - 1'b1;
            else if (dir_up)  ctr <= ctr + 1'b1;
            else              ctr <= ctr - 1'b1;
         end
      end
   end

   // R2 / R10: single steps between matches, including above the period
   a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      run && !ld_en && !zero_evt && !prd_evt && dir_up |=> ctr == CTR_W'($past(ctr) + 1'b1));
   a_r10_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      run && !ld_en && !zero_evt && !prd_evt && !dir_up |=> ctr == CTR_W'($past(ctr) - 1'b1));
   a_r2_rev_up: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt |=> dir_up);
   a_r2_rev_down: assert property (@(posedge clk) disable iff (!rst_n)
      prd_evt && !zero_evt |=> !dir_up);
   a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !ld_en |=> $stable(ctr) && $stable(dir_up));
   a_r9_no_evt: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> !zero_evt && !prd_evt && !cmp_evt);
   a_r9_keep_dir: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en && !zero_evt && !prd_evt |=> $stable(dir_up));
endmodule

// File: rtl/pwm_tb_regs.sv
module pwm_tb_regs
   import pwm_tb_pkg::*;
#(
   parameter int unsigned CTR_W     = 16,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned PRD_RESET = 1000,
   parameter bit          RD_ACTIVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CTR_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CTR_W-1:0]  rd_data,
   input  logic [CTR_W-1:0]  ctr,
   input  logic              dir_up,
   input  logic              zero_evt,
   output logic              run,
   output logic [CTR_W-1:0]  prd_act,
   output logic [CTR_W-1:0]  cmp_act,
   output logic              ld_en,
   output logic [CTR_W-1:0]  ld_val
);
   localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

   tb_mode_e         mode_q;
   logic             imm_q, max_q;
   logic [CTR_W-1:0] prd_sh, cmp_sh, prd_rd, cmp_rd;
   logic             wr_ctrl, wr_prd, wr_cmp, wr_stat, max_clr;

   assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
   assign wr_prd  = wr_en && (wr_addr == ADDR_W'(A_PRD));
   assign wr_cmp  = wr_en && (wr_addr == ADDR_W'(A_CMP));
   assign wr_stat = wr_en && (wr_addr == ADDR_W'(A_STAT));
   assign ld_en   = wr_en && (wr_addr == ADDR_W'(A_CNT));
   assign ld_val  = wr_data;
   assign max_clr = wr_stat && wr_data[1];
   assign run     = (mode_q == MODE_UPDN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= MODE_STOP;
         imm_q   <= 1'b0;
         max_q   <= 1'b0;
         prd_sh  <= CTR_W'(PRD_RESET);
         prd_act <= CTR_W'(PRD_RESET);
         cmp_sh  <= '0;
         cmp_act <= '0;
      end else begin
         if (wr_ctrl) begin
            mode_q <= tb_mode_e'(wr_data[1:0]);
            imm_q  <= wr_data[2];
         end
         if (wr_prd) prd_sh <= wr_data;
         if (wr_prd && imm_q)          prd_act <= wr_data;
         else if (zero_evt && !imm_q)  prd_act <= prd_sh;
         if (wr_cmp)   cmp_sh  <= wr_data;
         if (zero_evt) cmp_act <= cmp_sh;
         if (run && ctr == CTR_MAX) max_q <= 1'b1;
         else if (max_clr)          max_q <= 1'b0;
      end
   end

   generate
      if (RD_ACTIVE) begin : g_rd_act
         assign prd_rd = prd_act;
         assign cmp_rd = cmp_act;
      end else begin : g_rd_sh
         assign prd_rd = prd_sh;
         assign cmp_rd = cmp_sh;
      end
   endgenerate

   always_comb begin
      case (rd_addr)
         ADDR_W'(A_CTRL): rd_data = {{(CTR_W-3){1'b0}}, imm_q, mode_q};
         ADDR_W'(A_PRD):  rd_data = prd_rd;
         ADDR_W'(A_CNT):  rd_data = ctr;
         ADDR_W'(A_CMP):  rd_data = cmp_rd;
         ADDR_W'(A_STAT): rd_data = {{(CTR_W-2){1'b0}}, max_q, dir_up};
         default:         rd_data = '0;
      endcase
   end

   a_r8_max_hold: assert property (@(posedge clk) disable iff (!rst_n)
      max_q && !max_clr |=> max_q);
   a_r8_max_set: assert property (@(posedge clk) disable iff (!rst_n)
      run && ctr == CTR_MAX |=> max_q);
   a_r7_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !zero_evt |=> $stable(cmp_act));
   a_r6_prd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !imm_q && !zero_evt |=> $stable(prd_act));
endmodule

// File: rtl/pwm_tb_action.sv
module pwm_tb_action (
   input  logic clk,
   input  logic rst_n,
   input  logic zero_evt,
   input  logic prd_evt,
   output logic pwm_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)        pwm_q <= 1'b0;
      else if (zero_evt) pwm_q <= 1'b0;
      else if (prd_evt)  pwm_q <= 1'b1;
   end

   a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt |=> !pwm_q);
   a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
      prd_evt && !zero_evt |=> pwm_q);
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !zero_evt && !prd_evt |=> $stable(pwm_q));
endmodule

// File: rtl/pwm_updown_timebase.sv
module pwm_updown_timebase #(
   parameter int unsigned CTR_W     = 16,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned PRD_RESET = 1000,
   parameter bit          RD_ACTIVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CTR_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CTR_W-1:0]  rd_data,
   output logic [CTR_W-1:0]  ctr_o,
   output logic              zero_evt,
   output logic              prd_evt,
   output logic              cmp_evt,
   output logic              pwm_o
);
   generate
      if (CTR_W < 4) begin : g_bad_width
         $error("CTR_W must be at least 4");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must be at least 3");
      end
   endgenerate

   logic             run, dir_up, ld_en;
   logic [CTR_W-1:0] prd_act, cmp_act, ld_val;

   pwm_tb_regs #(
      .CTR_W(CTR_W), .ADDR_W(ADDR_W), .PRD_RESET(PRD_RESET), .RD_ACTIVE(RD_ACTIVE)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .ctr(ctr_o), .dir_up(dir_up),
      .zero_evt(zero_evt), .run(run), .prd_act(prd_act), .cmp_act(cmp_act),
      .ld_en(ld_en), .ld_val(ld_val)
   );

   pwm_tb_counter #(.CTR_W(CTR_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .run(run), .prd_act(prd_act), .cmp_act(cmp_act),
      .ld_en(ld_en), .ld_val(ld_val), .ctr(ctr_o), .dir_up(dir_up),
      .zero_evt(zero_evt), .prd_evt(prd_evt), .cmp_evt(cmp_evt)
   );

   pwm_tb_action act_i (
      .clk(clk), .rst_n(rst_n), .zero_evt(zero_evt), .prd_evt(prd_evt), .pwm_q(pwm_o)
   );
endmodule

// File: tb/pwm_updown_timebase_tb_top.sv
`timescale 1ns/1ps
module pwm_updown_timebase_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data, ctr_o;
   logic        zero_evt, prd_evt, cmp_evt, pwm_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [18:0] exp_q[$];

   always #2 clk = ~clk;

   pwm_updown_timebase dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .ctr_o(ctr_o), .zero_evt(zero_evt),
      .prd_evt(prd_evt), .cmp_evt(cmp_evt), .pwm_o(pwm_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   // mask bits: {cmp, prd, zero}
   task automatic expect_evt(input logic [2:0] m, input logic [15:0] c);
      exp_q.push_back({m, c});
   endtask

   // monitor: every event pulse is popped from the scoreboard and compared (R3)
   always @(negedge clk) begin
      if (rst_n && (zero_evt || prd_evt || cmp_evt)) begin
         if (exp_q.size() == 0) begin
            chk("R3 unexpected event", {13'd0, cmp_evt, prd_evt, zero_evt, ctr_o}, 32'hFFFF_FFFF);
         end else begin
            logic [18:0] e;
            e = exp_q.pop_front();
            chk("R3 event/counter", {13'd0, cmp_evt, prd_evt, zero_evt, ctr_o}, {13'd0, e});
         end
      end
   end

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 counter", ctr_o, 0);
      rd(3'd4, v); chk("R1 status", v, 16'h0001);
      chk("R1 pwm", pwm_o, 0);
      rd(3'd0, v); chk("R1 control", v, 0);

      // Scenario A: immediate period 10, compare 4
      wr(3'd0, 16'h4);
      wr(3'd1, 16'd10);
      rd(3'd1, v); chk("R6 immediate period", v, 10);
      wr(3'd3, 16'd4);
      rd(3'd3, v); chk("R7 compare not yet active", v, 0);
      expect_evt(3'b101, 0); expect_evt(3'b100, 4); expect_evt(3'b010, 10);
      expect_evt(3'b100, 4); expect_evt(3'b001, 0);
      wr(3'd0, 16'h5);                       // t0
      repeat (5) @(negedge clk);             // t5
      chk("R2 rising count", ctr_o, 5);
      rd(3'd4, v); chk("R2 dir up", v[0], 1);
      repeat (10) @(negedge clk);            // t15
      chk("R2 falling count", ctr_o, 5);
      rd(3'd4, v); chk("R2 dir down", v[0], 0);
      chk("R4 pwm set after period", pwm_o, 1);
      repeat (5) @(negedge clk);             // t20
      wr(3'd0, 16'h6);                       // mode 10 stops, t21
      chk("R4 pwm cleared after zero", pwm_o, 0);
      chk("R5 counter at stop", ctr_o, 1);
      repeat (6) @(negedge clk);
      chk("R5 counter frozen", ctr_o, 1);
      rd(3'd4, v); chk("R5 dir held", v[0], 1);
      chk("R3 scoreboard drained A", exp_q.size(), 0);

      // Scenario B: write 0 while falling
      expect_evt(3'b100, 4); expect_evt(3'b010, 10);
      wr(3'd0, 16'h5);                       // s0, ctr 1
      repeat (12) @(negedge clk);            // s12
      chk("R2 falling before write", ctr_o, 7);
      wr(3'd2, 16'd0);                       // s13
      chk("R9 written value", ctr_o, 0);
      rd(3'd4, v); chk("R9 dir kept down", v[0], 0);
      @(negedge clk);                        // s14
      chk("R10 underflow", ctr_o, 16'hFFFF);
      @(negedge clk);                        // s15
      chk("R10 above period falling", ctr_o, 16'hFFFE);
      rd(3'd4, v); chk("R8 max flag set", v[1], 1);
      expect_evt(3'b001, 0);
      wr(3'd2, 16'd3);                       // s16
      repeat (4) @(negedge clk);             // s20
      chk("R10 resumed rising", ctr_o, 1);
      rd(3'd4, v); chk("R10 dir up after zero", v[0], 1);
      chk("R8 max latched", v[1], 1);
      wr(3'd4, 16'h0);
      rd(3'd4, v); chk("R8 write 0 ignored", v[1], 1);
      wr(3'd4, 16'h2);                       // s22, ctr 3
      rd(3'd4, v); chk("R8 cleared by 1", v[1], 0);

      // Scenario C: force period value while rising
      wr(3'd2, 16'd10);                      // s23
      @(negedge clk);                        // s24
      chk("R11 passes period", ctr_o, 11);
      rd(3'd4, v); chk("R11 dir still up", v[0], 1);
      wr(3'd0, 16'h4);
      chk("R3 scoreboard drained BC", exp_q.size(), 0);

      // Scenario D: buffered period and compare
      wr(3'd2, 16'd0);
      wr(3'd0, 16'h0);
      wr(3'd1, 16'd6);
      rd(3'd1, v); chk("R6 buffered period held", v, 10);
      expect_evt(3'b001, 0); expect_evt(3'b100, 4); expect_evt(3'b010, 6);
      expect_evt(3'b100, 4); expect_evt(3'b001, 0);
      wr(3'd0, 16'h1);                       // r0
      @(negedge clk);                        // r1
      rd(3'd1, v); chk("R6 period moved on zero", v, 6);
      wr(3'd3, 16'd2);                       // r2
      rd(3'd3, v); chk("R7 compare held", v, 4);
      repeat (11) @(negedge clk);            // r13
      rd(3'd3, v); chk("R7 compare moved on zero", v, 2);
      wr(3'd0, 16'h0);                       // r14
      repeat (3) @(negedge clk);
      chk("R5 stopped after D", ctr_o, 2);
      chk("R3 scoreboard drained D", exp_q.size(), 0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule